// File: doc/BRIEF.md
# Request-Driven Serial Burst Read Master

This block is the host side of a two-wire serial control link toward a peripheral that announces pending data by pulling an active-low request line. While the request line is high the bus stays idle. Once the line goes low, the master issues a start condition and sends the 7-bit peripheral address followed by a read bit. It then checks the acknowledge and clocks in data bytes one after another, presenting each on a byte-wide output with a one-cycle valid strobe.

The length of a burst is not fixed. The peripheral keeps its request line low for as long as bytes remain and raises it while the last bit of the final byte is clocked. The master samples the request line at the sampling point of the last bit of every byte. If the line is still low, it acknowledges that byte and continues. If the line is high, it answers with a not-acknowledge and closes the burst with a stop condition. A missing acknowledge on the address byte makes the master stop and try the whole read again, up to a programmable number of retries. When the retries are used up it raises an error strobe.

The serial clock comes from a programmable divider of the system clock, and each bit cell lasts four divider periods. The data line is only ever pulled low or released, as on an open-drain bus. Both incoming lines pass through two-stage synchronizers.

Top module: `irq_i2c_burst_reader`

## Requirements
- R1: While the synchronized request line is high and no transfer is active, `scl_o` stays 1 and `sda_oe` stays 0, so no start condition is issued.
- R2: A low request line starts a transfer. The data line is pulled low while the clock is high, and then 8 bits are sent MSB first: the 7 bits of `dev_addr` followed by a 1 in the least significant position (read).
- R3: If the address byte is not acknowledged (data line high at the ninth clock), the master issues a stop and restarts the whole read. After `MAX_RETRY` retries have failed (MAX_RETRY+1 attempts in all), it pulses `err` for one cycle, pulses no `done`, delivers no bytes and returns to idle.
- R4: Outside start and stop conditions, `sda_oe` changes only while `scl_o` is low. Incoming bits are sampled while `scl_o` is high.
- R5: If the request line is still low when the last bit (bit 0) of a byte is sampled, the master pulls the data line low in the following acknowledge clock and reads another byte. It never stops while the request line is low.
- R6: If the request line is high when bit 0 of a byte is sampled, the master leaves the data line high in that byte's acknowledge clock (not-acknowledge) and then issues a stop.
- R7: A stop is the data line rising while the clock is high. After a stop that ends a successful burst, `done` pulses for exactly one cycle and `err` stays 0.
- R8: Each received byte appears on `rd_data`, with the first bit received as bit 7. `rd_valid` is high for exactly one cycle per byte, and there is one pulse for every byte clocked in.
- R9: One serial clock period lasts 4*DIV system clock cycles.
- R10: While `rst` is high the outputs are `scl_o`=1, `sda_oe`=0, `rd_valid`=0, `done`=0 and `err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 1 | Active-low data request from the peripheral |
| dev_addr | input | 7 | Peripheral address sent in the address byte |
| sda_i | input | 1 | Level seen on the serial data line |
| scl_o | output | 1 | Serial clock |
| sda_oe | output | 1 | 1 pulls the serial data line low, 0 releases it |
| rd_valid | output | 1 | One-cycle strobe for a received byte |
| rd_data | output | 8 | Received byte, first bit received in bit 7 |
| done | output | 1 | One-cycle strobe after a successful burst ends |
| err | output | 1 | One-cycle strobe when the address retries are exhausted |

## Verification
The bench builds the block with DIV=4 and MAX_RETRY=2. The short bit cell lets bursts of up to six bytes, several with address rejections first, finish in a few thousand cycles, while it still leaves a full divider period between the peripheral raising its request line and the master sampling it. With a retry cap of two, a third rejected address is enough to reach the error path, and one or two rejections followed by success cover the restart path.

// File: rtl/irb_pkg.sv
package irb_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_AACK,
        ST_DATA,
        ST_MACK,
        ST_STOP
    } irb_state_e;

    typedef logic [1:0] quarter_t;

    localparam quarter_t Q_SAMPLE = 2'd2;
    localparam quarter_t Q_LAST   = 2'd3;

    typedef struct packed {
        logic [BYTE_BITS-1:0] data;
        logic                 valid;
    } rx_beat_t;

    // Clock level for every state and quarter of the bit cell.
    function automatic logic scl_level(irb_state_e st, quarter_t q);
        logic lvl;
        unique case (st)
            ST_IDLE:  lvl = 1'b1;
            ST_START: lvl = (q != 2'd3);
            ST_STOP:  lvl = (q != 2'd0);
            default:  lvl = q[1];
        endcase
        return lvl;
    endfunction

    // Pull-low request for the data line.
    function automatic logic sda_pull(irb_state_e st, quarter_t q,
                                      logic tx_bit, logic keep_going);
        logic pull;
        unique case (st)
            ST_IDLE:  pull = 1'b0;
            ST_START: pull = (q != 2'd0);
            ST_ADDR:  pull = ~tx_bit;
            ST_MACK:  pull = keep_going;
            ST_STOP:  pull = (q < 2'd2);
            default:  pull = 1'b0;
        endcase
        return pull;
    endfunction

endpackage

// File: rtl/irb_sync.sv
module irb_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '1;
            stage2 <= '1;
        end else begin
            stage1 <= async_i;
            stage2 <= stage1;
        end
    end

    assign sync_o = stage2;
endmodule

// File: rtl/irb_tick.sv
module irb_tick #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == TOP) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == TOP);
endmodule

// File: rtl/irq_i2c_burst_reader.sv
module irq_i2c_burst_reader
    import irb_pkg::*;
#(
    parameter int DIV       = 125,
    parameter int MAX_RETRY = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_n,
    input  logic [6:0] dev_addr,
    input  logic       sda_i,
    output logic       scl_o,
    output logic       sda_oe,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       done,
    output logic       err
);
    localparam int RETRY_W = $clog2(MAX_RETRY + 2);
    localparam int IDX_W   = $clog2(BYTE_BITS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_BITS - 1);
    localparam logic [RETRY_W-1:0] RETRY_CAP = RETRY_W'(MAX_RETRY);

    irb_state_e           state;
    quarter_t             phase;
    logic [IDX_W-1:0]     bit_idx;
    logic [BYTE_BITS-1:0] shreg;
    logic                 more;
    logic                 nacked;
    logic [RETRY_W-1:0]   retries;
    rx_beat_t             rx_q;
    logic                 done_q;
    logic                 err_q;

    logic [1:0] sync_q;
    logic       req_s;
    logic       sda_s;
    logic       tick;

    irb_sync #(.W(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({req_n, sda_i}),
        .sync_o  (sync_q)
    );

    assign req_s = sync_q[1];
    assign sda_s = sync_q[0];

    irb_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (state != ST_IDLE),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            phase   <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            more    <= 1'b0;
            nacked  <= 1'b0;
            retries <= '0;
            rx_q    <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            rx_q.valid <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            if (state == ST_IDLE) begin
                if (!req_s) begin
                    state   <= ST_START;
                    shreg   <= {dev_addr, 1'b1};
                    phase   <= '0;
                    bit_idx <= '0;
                    nacked  <= 1'b0;
                    more    <= 1'b0;
                end
            end else if (tick) begin
                phase <= phase + 1'b1;
                unique case (state)
                    ST_START: begin
                        if (phase == Q_LAST) state <= ST_ADDR;
                    end
                    ST_ADDR: begin
                        if (phase == Q_LAST) begin
                            shreg   <= shreg << 1;
                            bit_idx <= bit_idx + 1'b1;
                            if (bit_idx == IDX_LAST) state <= ST_AACK;
                        end
                    end
                    ST_AACK: begin
                        if (phase == Q_SAMPLE) nacked <= sda_s;
                        if (phase == Q_LAST) begin
                            state   <= nacked ? ST_STOP : ST_DATA;
                            bit_idx <= '0;
                        end
                    end
                    ST_DATA: begin
                        if (phase == Q_SAMPLE) begin
                            shreg <= {shreg[BYTE_BITS-2:0], sda_s};
                            if (bit_idx == IDX_LAST) begin
                                rx_q.valid <= 1'b1;
                                rx_q.data  <= {shreg[BYTE_BITS-2:0], sda_s};
                                more       <= ~req_s;
                            end
                        end
                        if (phase == Q_LAST) begin
                            bit_idx <= bit_idx + 1'b1;
                            if (bit_idx == IDX_LAST) state <= ST_MACK;
                        end
                    end
                    ST_MACK: begin
                        if (phase == Q_LAST) state <= more ? ST_DATA : ST_STOP;
                    end
                    ST_STOP: begin
                        if (phase == Q_LAST) begin
                            state  <= ST_IDLE;
                            nacked <= 1'b0;
                            if (nacked) begin
                                if (retries == RETRY_CAP) begin
                                    err_q   <= 1'b1;
                                    retries <= '0;
                                end else begin
                                    retries <= retries + 1'b1;
                                end
                            end else begin
                                done_q  <= 1'b1;
                                retries <= '0;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign scl_o    = scl_level(state, phase);
    assign sda_oe   = sda_pull(state, phase, shreg[BYTE_BITS-1], more);
    assign rd_valid = rx_q.valid;
    assign rd_data  = rx_q.data;
    assign done     = done_q;
    assign err      = err_q;

endmodule

// File: rtl/irb_checker.sv
module irb_checker
    import irb_pkg::*;
#(
    parameter int MAX_RETRY = 3,
    parameter int RETRY_W   = 3
) (
    input logic               clk,
    input logic               rst,
    input irb_state_e         state,
    input quarter_t           phase,
    input logic               tick,
    input logic               more,
    input logic [RETRY_W-1:0] retries,
    input logic               scl_o,
    input logic               sda_oe,
    input logic               rd_valid,
    input logic               done,
    input logic               err
);
    logic in_bits;
    assign in_bits = (state == ST_ADDR) || (state == ST_AACK) ||
                     (state == ST_DATA) || (state == ST_MACK);

    // R1: idle bus is released
    a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (scl_o && !sda_oe));

    // R4: data line holds while the clock stays high inside bit cells
    a_r4_sda_hold_high: assert property (@(posedge clk) disable iff (rst)
        (in_bits && $past(in_bits) && scl_o && $past(scl_o)) |-> $stable(sda_oe));

    // R5: acknowledged byte leads to another byte
    a_r5_ack_continues: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MACK && tick && phase == 2'd3 && more) |=> (state == ST_DATA));

    // R6: rejected byte leads to stop
    a_r6_nack_stops: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MACK && tick && phase == 2'd3 && !more) |=> (state == ST_STOP));

    // R7: done and err never together, done only after a stop
    a_r7_done_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(done && err));
    a_r7_done_after_stop: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(state) == ST_STOP));

    // R3: retry counter never exceeds its cap
    a_r3_retry_cap: assert property (@(posedge clk) disable iff (rst)
        retries <= RETRY_W'(MAX_RETRY));

    // R8: byte strobe lasts one cycle
    a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

endmodule

bind irq_i2c_burst_reader irb_checker #(
    .MAX_RETRY (MAX_RETRY),
    .RETRY_W   (RETRY_W)
) u_irb_chk (
    .clk      (clk),
    .rst      (rst),
    .state    (state),
    .phase    (phase),
    .tick     (tick),
    .more     (more),
    .retries  (retries),
    .scl_o    (scl_o),
    .sda_oe   (sda_oe),
    .rd_valid (rd_valid),
    .done     (done),
    .err      (err)
);

// File: tb/irq_i2c_burst_reader_bench.sv
`timescale 1ns/1ps
module irq_i2c_burst_reader_bench;
    localparam int DIV       = 4;
    localparam int MAX_RETRY = 2;
    localparam int NV        = 8;

    // {byte count[13:10], address rejections[9:8], seed[7:0]}
    localparam logic [13:0] VEC [NV] = '{
        {4'd1, 2'd0, 8'hA5},
        {4'd3, 2'd0, 8'h3C},
        {4'd2, 2'd1, 8'h00},
        {4'd5, 2'd0, 8'hFF},
        {4'd4, 2'd2, 8'h5A},
        {4'd1, 2'd1, 8'h81},
        {4'd6, 2'd0, 8'h17},
        {4'd2, 2'd2, 8'hC3}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_n = 1'b1;
    logic [6:0] dev_addr = '0;
    logic       slave_low = 1'b0;
    wire        sda_bus;
    logic       scl_o, sda_oe, rd_valid, done, err;
    logic [7:0] rd_data;

    int tests = 0;
    int fails = 0;
    int vcnt = 0, dcnt = 0, ecnt = 0;
    int cyc = 0;
    logic [7:0] got [64];

    always #4 clk = ~clk;

    assign sda_bus = !(sda_oe || slave_low);

    irq_i2c_burst_reader #(.DIV(DIV), .MAX_RETRY(MAX_RETRY)) u_irq_i2c_burst_reader (
        .clk      (clk),
        .rst      (rst),
        .req_n    (req_n),
        .dev_addr (dev_addr),
        .sda_i    (sda_bus),
        .scl_o    (scl_o),
        .sda_oe   (sda_oe),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .done     (done),
        .err      (err)
    );

    always @(posedge clk) cyc = cyc + 1;

    always @(negedge clk) begin
        if (rd_valid) begin
            got[vcnt % 64] = rd_data;
            vcnt = vcnt + 1;
        end
        if (done) dcnt = dcnt + 1;
        if (err)  ecnt = ecnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [7:0] s, input int k);
        return 8'(s + k * 61);
    endfunction

    task automatic wait_start();
        forever begin
            @(negedge sda_bus);
            if (scl_o === 1'b1) break;
        end
    endtask

    task automatic wait_stop();
        forever begin
            @(posedge sda_bus);
            if (scl_o === 1'b1) break;
        end
    endtask

    // Peripheral model: answers the address, shifts out bytes, raises its
    // request line at the rising clock of bit 0 of the last byte.
    task automatic slave_run(input int nb, input int na, input logic [7:0] seed,
                             input logic [6:0] addr, output int attempts);
        logic [7:0] rx;
        logic [7:0] dat;
        logic       acked;
        logic       mack;
        int         t0;
        attempts = 0;
        acked    = 1'b0;
        while (!acked) begin
            wait_start();
            attempts++;
            rx = '0;
            for (int b = 0; b < 8; b++) begin
                @(posedge scl_o);
                if (b == 0) t0 = cyc;
                if (b == 1) chk((cyc - t0) == 4 * DIV, "R9 clock period", cyc - t0, 4 * DIV);
                rx = {rx[6:0], sda_bus};
            end
            chk(rx == {addr, 1'b1}, "R2 address byte", rx, {addr, 1'b1});
            @(negedge scl_o);
            acked = (attempts > na);
            slave_low = acked;
            @(posedge scl_o);
            if (!acked && attempts == MAX_RETRY + 1) req_n = 1'b1;
            @(negedge scl_o);
            slave_low = 1'b0;
            if (!acked) begin
                wait_stop();
                chk(1'b1, "R3 stop after rejected address", 1, 1);
                if (attempts == MAX_RETRY + 1) return;
            end
        end
        for (int k = 0; k < nb; k++) begin
            dat = exp_byte(seed, k);
            for (int b = 7; b >= 0; b--) begin
                slave_low = ~dat[b];
                @(posedge scl_o);
                if (k == nb - 1 && b == 0) req_n = 1'b1;
                @(negedge scl_o);
            end
            slave_low = 1'b0;
            @(posedge scl_o);
            mack = sda_bus;
            if (k == nb - 1)
                chk(mack == 1'b1, "R6 not-acknowledge on last byte", mack, 1);
            else
                chk(mack == 1'b0, "R5 acknowledge while request low", mack, 0);
            @(negedge scl_o);
        end
        wait_stop();
        chk(1'b1, "R7 stop after last byte", 1, 1);
    endtask

    task automatic quiet_check(input int n, input string tag);
        bit ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (scl_o !== 1'b1 || sda_oe !== 1'b0) ok = 1'b0;
        end
        chk(ok, tag, {scl_o, sda_oe}, 2'b10);
    endtask

    task automatic run_case(input int nb, input int na, input logic [7:0] seed);
        int vb, db, eb, att;
        bit is_err;
        logic [6:0] addr;
        addr = seed[6:0] ^ 7'h35;
        is_err = (na > MAX_RETRY);
        @(negedge clk);
        dev_addr = addr;
        vb = vcnt; db = dcnt; eb = ecnt;
        req_n = 1'b0;
        slave_run(nb, na, seed, addr, att);
        repeat (60) @(negedge clk);
        chk(att == (is_err ? MAX_RETRY + 1 : na + 1), "R3 attempt count", att,
            is_err ? MAX_RETRY + 1 : na + 1);
        chk((ecnt - eb) == (is_err ? 1 : 0), "R3 err strobe", ecnt - eb, is_err ? 1 : 0);
        chk((dcnt - db) == (is_err ? 0 : 1), "R7 done strobe", dcnt - db, is_err ? 0 : 1);
        chk((vcnt - vb) == (is_err ? 0 : nb), "R8 byte count", vcnt - vb, is_err ? 0 : nb);
        if (!is_err) begin
            for (int k = 0; k < nb; k++)
                chk(got[(vb + k) % 64] == exp_byte(seed, k), "R8 byte value",
                    got[(vb + k) % 64], exp_byte(seed, k));
        end
        quiet_check(40, "R1 idle after transfer");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R7 watchdog: actual hang expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10: reset values
        chk(scl_o === 1'b1 && sda_oe === 1'b0 && rd_valid === 1'b0 &&
            done === 1'b0 && err === 1'b0, "R10 reset outputs",
            {scl_o, sda_oe, rd_valid, done, err}, 5'b10000);
        rst = 1'b0;
        quiet_check(100, "R1 no start while request high");

        for (int v = 0; v < NV; v++)
            run_case(int'(VEC[v][13:10]), int'(VEC[v][9:8]), VEC[v][7:0]);

        // Directed: retries exhausted (R3), bus stays idle afterwards (R1)
        run_case(2, 3, 8'h6E);
        // Directed: normal burst right after an error
        run_case(3, 0, 8'h29);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule